// File: doc/BRIEF.md
# Sampled Compression Utility Controller

This block decides whether a memory controller pairs lines for compression across most of memory. A fixed subset of sets always compresses: a set is in that subset when its index divided by the sample period (100 by default) leaves no remainder. Activity on those sets acts as a running experiment. A useful neighbour line delivered at no extra cost counts as a benefit. An extra access after a location misprediction, or traffic spent moving lines when their compressibility changes, counts as a cost. Both feed one saturating utility counter.

The remaining sets follow a single policy bit that comes from the counter. The policy bit is set while the counter sits at or above its midpoint and is cleared once the counter falls two steps below it, so it does not toggle around the boundary. For each request, the controller returns a compress or do-not-pair decision, computed combinationally from the request's set index and the registered policy bit.

Top module: `comp_util_ctrl`

## Requirements
- R1: After reset, `util_count` is 2048 and `policy_en` is 1.
- R2: A valid request whose set index modulo 100 equals 0 gets `req_compress`=1, whatever the counter value.
- R3: A valid request on any other set gets `req_compress` equal to `policy_en`. When `req_valid` is 0, `req_compress` is 0.
- R4: A benefit pulse with a sampled `evt_set` raises the counter by 1.
- R5: Each cost pulse (`evt_mispredict`, `evt_relocate`) with a sampled `evt_set` lowers the counter by 1. Both pulses in the same cycle lower it by 2.
- R6: Event pulses whose `evt_set` is not sampled leave the counter and `policy_en` unchanged.
- R7: A benefit pulse and one cost pulse in the same cycle cancel, leaving the counter unchanged.
- R8: The counter saturates at 4096 and never exceeds it.
- R9: The counter saturates at 0 and never wraps below it.
- R10: `policy_en` is 1 whenever the counter is at least 2048 and 0 whenever it is at most 2046. At 2047 it keeps its previous value.
- R11: The counter and `policy_en` take their new values at the clock edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is asking for a decision this cycle |
| req_set | input | 16 | Set index of the request |
| req_compress | output | 1 | 1: pair lines for compression; 0: store uncompressed |
| req_sampled | output | 1 | The request set belongs to the always-compress sample |
| evt_set | input | 16 | Set index that the event pulses refer to |
| evt_benefit | input | 1 | A free neighbour line turned out useful |
| evt_mispredict | input | 1 | A location misprediction cost a second access |
| evt_relocate | input | 1 | Bandwidth was spent relocating lines |
| util_count | output | 13 | Current utility counter value |
| policy_en | output | 1 | Compression policy applied to non-sampled sets |

## Verification
The states that are hardest to reach are the two rails and the single hysteresis value 2047. The rails lie 2048 net steps away from reset. The stimulus reaches them with long runs of sampled events, either paired costs or single benefits, and then pushes a few more events past each rail. The hold value at 2047 is approached from both directions, once while the policy is off and once while it is on. The stimulus also sends events on unsampled sets and combined benefit-and-cost pulses, which must leave the counter unchanged even though pulses are present.

// File: rtl/comp_util_pkg.sv
package comp_util_pkg;
  localparam int unsigned SET_W         = 16;
  localparam int unsigned SAMPLE_PERIOD = 100;
  localparam int unsigned CNT_W         = 13;
  localparam int unsigned CNT_MAX       = 4096;
  localparam int unsigned CNT_MID       = 2048;

  typedef struct packed {
    logic benefit;
    logic mispredict;
    logic relocate;
  } util_evt_t;
endpackage

// File: rtl/set_sampler.sv
module set_sampler #(
  parameter int unsigned SET_W  = 16,
  parameter int unsigned PERIOD = 100
) (
  input  logic [SET_W-1:0] set_idx,
  output logic             sampled
);
  localparam logic [SET_W-1:0] PERIOD_V = SET_W'(PERIOD);

  always_comb begin
    sampled = ((set_idx % PERIOD_V) == '0);
  end
endmodule

// File: rtl/util_counter.sv
module util_counter #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned CNT_MAX = 4096,
  parameter int unsigned CNT_INIT = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [1:0]       dec,
  output logic [CNT_W-1:0] cnt_d,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int unsigned SW = CNT_W + 2;
  localparam logic signed [SW-1:0] MAX_S = SW'(CNT_MAX);

  logic signed [SW-1:0] cur_s;
  logic signed [SW-1:0] delta_s;
  logic signed [SW-1:0] sum_s;

  always_comb begin
    cur_s   = $signed({2'b00, cnt_q});
    delta_s = $signed(SW'(inc)) - $signed(SW'(dec));
    sum_s   = cur_s + delta_s;
    cnt_load = inc | (|dec);
    if (sum_s < 0) begin
      cnt_d = '0;
    end else if (sum_s > MAX_S) begin
      cnt_d = CNT_W'(CNT_MAX);
    end else begin
      cnt_d = sum_s[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(CNT_INIT);
    end else if (cnt_load) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/policy_hyst.sv
module policy_hyst #(
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned THRESH = 2048,
  parameter bit          EN_INIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_d,
  output logic             en_q
);
  localparam logic [CNT_W-1:0] ON_LVL  = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] OFF_LVL = CNT_W'(THRESH - 1);

  logic en_d;

  always_comb begin
    en_d = en_q;
    if (cnt_d >= ON_LVL) begin
      en_d = 1'b1;
    end else if (cnt_d < OFF_LVL) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= EN_INIT;
    end else if (load) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/comp_util_ctrl.sv
module comp_util_ctrl
  import comp_util_pkg::*;
#(
  parameter int unsigned P_SET_W   = SET_W,
  parameter int unsigned P_PERIOD  = SAMPLE_PERIOD,
  parameter int unsigned P_CNT_W   = CNT_W,
  parameter int unsigned P_CNT_MAX = CNT_MAX,
  parameter int unsigned P_CNT_MID = CNT_MID
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [P_SET_W-1:0] req_set,
  output logic               req_compress,
  output logic               req_sampled,
  input  logic [P_SET_W-1:0] evt_set,
  input  logic               evt_benefit,
  input  logic               evt_mispredict,
  input  logic               evt_relocate,
  output logic [P_CNT_W-1:0] util_count,
  output logic               policy_en
);
  util_evt_t          evt;
  logic               evt_sampled;
  logic               inc;
  logic [1:0]         dec;
  logic [P_CNT_W-1:0] cnt_d;
  logic               cnt_load;

  set_sampler #(.SET_W(P_SET_W), .PERIOD(P_PERIOD)) u_req_samp (
    .set_idx (req_set),
    .sampled (req_sampled)
  );

  set_sampler #(.SET_W(P_SET_W), .PERIOD(P_PERIOD)) u_evt_samp (
    .set_idx (evt_set),
    .sampled (evt_sampled)
  );

  always_comb begin
    evt.benefit    = evt_benefit;
    evt.mispredict = evt_mispredict;
    evt.relocate   = evt_relocate;
    inc = evt_sampled & evt.benefit;
    dec = evt_sampled ? ({1'b0, evt.mispredict} + {1'b0, evt.relocate}) : 2'b00;
  end

  util_counter #(.CNT_W(P_CNT_W), .CNT_MAX(P_CNT_MAX), .CNT_INIT(P_CNT_MID)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .dec      (dec),
    .cnt_d    (cnt_d),
    .cnt_load (cnt_load),
    .cnt_q    (util_count)
  );

  policy_hyst #(.CNT_W(P_CNT_W), .THRESH(P_CNT_MID), .EN_INIT(1'b1)) u_pol (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cnt_load),
    .cnt_d (cnt_d),
    .en_q  (policy_en)
  );

  always_comb begin
    req_compress = req_valid & (req_sampled | policy_en);
  end
endmodule

// File: rtl/comp_util_ctrl_chk.sv
module comp_util_ctrl_chk #(
  parameter int unsigned P_SET_W   = 16,
  parameter int unsigned P_PERIOD  = 100,
  parameter int unsigned P_CNT_W   = 13,
  parameter int unsigned P_CNT_MAX = 4096,
  parameter int unsigned P_CNT_MID = 2048
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [P_SET_W-1:0] req_set,
  input logic               req_compress,
  input logic               req_sampled,
  input logic [P_SET_W-1:0] evt_set,
  input logic               evt_benefit,
  input logic               evt_mispredict,
  input logic               evt_relocate,
  input logic [P_CNT_W-1:0] util_count,
  input logic               policy_en
);
  logic any_evt;
  assign any_evt = evt_benefit | evt_mispredict | evt_relocate;

  // R8: the counter stays within its upper rail
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    util_count <= P_CNT_W'(P_CNT_MAX));

  // R10: at or above the midpoint the policy is on
  assert_policy_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (util_count >= P_CNT_W'(P_CNT_MID)) |-> policy_en);

  // R10: two or more below the midpoint the policy is off
  assert_policy_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (util_count < P_CNT_W'(P_CNT_MID - 1)) |-> !policy_en);

  // R6: without event pulses nothing changes
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> ($stable(util_count) && $stable(policy_en)));

  // R7: a benefit cancelled by one cost leaves the counter alone
  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_benefit && (evt_mispredict ^ evt_relocate)) |=> $stable(util_count));

  // R2: a sampled valid request is always compressed
  assert_sampled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sampled) |-> req_compress);

  // R3: a non-sampled request follows the policy, and no request means no decision
  assert_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sampled) |-> (req_compress == policy_en));
  assert_idle_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_compress);

  // R9: the counter never jumps from the bottom to the top
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (util_count == '0 && !evt_benefit) |=> (util_count == '0));
endmodule

bind comp_util_ctrl comp_util_ctrl_chk #(
  .P_SET_W(P_SET_W), .P_PERIOD(P_PERIOD), .P_CNT_W(P_CNT_W),
  .P_CNT_MAX(P_CNT_MAX), .P_CNT_MID(P_CNT_MID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
  .req_compress(req_compress), .req_sampled(req_sampled), .evt_set(evt_set),
  .evt_benefit(evt_benefit), .evt_mispredict(evt_mispredict),
  .evt_relocate(evt_relocate), .util_count(util_count), .policy_en(policy_en)
);

// File: tb/tb_comp_util_ctrl.sv
module tb_comp_util_ctrl;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_set;
  logic        req_compress;
  logic        req_sampled;
  logic [15:0] evt_set;
  logic        evt_benefit;
  logic        evt_mispredict;
  logic        evt_relocate;
  logic [12:0] util_count;
  logic        policy_en;

  int checks;
  int fails;
  int m_cnt;
  bit m_en;

  typedef struct {
    int    cnt;
    bit    en;
    string tag;
  } exp_t;
  exp_t q[$];

  comp_util_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
    .req_compress(req_compress), .req_sampled(req_sampled), .evt_set(evt_set),
    .evt_benefit(evt_benefit), .evt_mispredict(evt_mispredict),
    .evt_relocate(evt_relocate), .util_count(util_count), .policy_en(policy_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare the registered outputs against queued expectations
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(int'(util_count) == e.cnt, {e.tag, " count"}, int'(util_count), e.cnt);
      check(policy_en == e.en, {e.tag, " policy"}, int'(policy_en), int'(e.en));
    end
  end

  function automatic bit is_sampled(input int s);
    return (s % 100) == 0;
  endfunction

  // driver: apply one cycle of events and push the model's expectation
  task automatic ev(input int s, input bit b, input bit m, input bit r, input string tag);
    exp_t e;
    @(negedge clk);
    evt_set = 16'(s);
    evt_benefit = b;
    evt_mispredict = m;
    evt_relocate = r;
    if (is_sampled(s)) begin
      m_cnt = m_cnt + int'(b) - int'(m) - int'(r);
      if (m_cnt < 0) m_cnt = 0;
      if (m_cnt > 4096) m_cnt = 4096;
      if (m_cnt >= 2048) m_en = 1'b1;
      else if (m_cnt <= 2046) m_en = 1'b0;
    end
    @(posedge clk);
    e.cnt = m_cnt;
    e.en = m_en;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic req(input int s, input bit v, input string tag);
    bit expv;
    @(negedge clk);
    evt_benefit = 1'b0;
    evt_mispredict = 1'b0;
    evt_relocate = 1'b0;
    req_valid = v;
    req_set = 16'(s);
    #1;
    expv = v && (is_sampled(s) || m_en);
    check(req_compress == expv, tag, int'(req_compress), int'(expv));
  endtask

  initial begin
    #1ms;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    m_cnt = 2048; m_en = 1'b1;
    rst_n = 1'b0; req_valid = 1'b0; req_set = '0; evt_set = '0;
    evt_benefit = 1'b0; evt_mispredict = 1'b0; evt_relocate = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(util_count == 13'd2048, "R1 reset count", int'(util_count), 2048);
    check(policy_en == 1'b1, "R1 reset policy", int'(policy_en), 1);

    ev(0, 1, 0, 0, "R4 benefit R11");           // 2049
    ev(1, 1, 0, 0, "R6 unsampled benefit");
    ev(99, 0, 1, 1, "R6 unsampled cost");
    ev(200, 1, 1, 0, "R7 cancel");
    ev(300, 1, 0, 1, "R7 cancel reloc");
    ev(0, 0, 1, 0, "R5 mispredict");           // 2048
    ev(100, 0, 1, 1, "R5 double cost R10 off"); // 2046 off
    ev(0, 1, 0, 0, "R10 hold off at 2047");     // 2047 off
    req(1, 1, "R3 follow off");
    req(100, 1, "R2 sampled while off");
    ev(0, 1, 0, 0, "R10 on at 2048");           // 2048 on
    ev(0, 0, 0, 1, "R10 hold on at 2047");      // 2047 on
    req(1, 1, "R3 follow on");
    req(1, 0, "R3 no request");
    req(0, 0, "R3 no request sampled");

    for (int i = 0; i < 1030; i++) ev(0, 0, 1, 1, "R9 descend");
    for (int i = 0; i < 4; i++) ev(65500, 0, 1, 0, "R9 floor");
    req(101, 1, "R3 follow at floor");
    req(65500, 1, "R2 sampled at floor");
    ev(0, 1, 1, 0, "R7 cancel at floor");
    for (int i = 0; i < 4100; i++) ev(0, 1, 0, 0, "R8 ascend");
    ev(100, 1, 0, 0, "R8 ceiling");
    req(7, 1, "R3 follow at ceiling");

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule